// File: doc/BRIEF.md
# Power Button and Reset Request Controller

This block turns a debounced power-button level, a lid-open level and a warm-reset request from the application processor into power-on requests, forced shutdowns and timed reset pulses for a power sequencer. A millisecond tick paces every timer. The block sits beside the sequencer. Its active-low system reset and PMIC enable outputs are combined with the sequencer's own outputs, and its single-cycle power-on and forced-shutdown pulses go to the sequencer.

A button press while the system is off starts a short boot hold and a long shutdown hold. A press while the system is on starts only the shutdown hold. Releasing the button cancels whatever is still pending. A forced shutdown pulls both the reset and the PMIC enable low. It keeps the PMIC enable low for a long window, and a new boot hold that completes cuts that window short. The button state machine has four states. BT_IDLE waits for a press and goes to BT_BOOT_WAIT when the system is off, otherwise to BT_HOLD. BT_BOOT_WAIT goes to BT_HOLD when the boot hold completes, and to BT_SPENT if the shutdown hold completes first. BT_HOLD goes to BT_SPENT when the shutdown hold completes or the sequencer reports entry to S3. Every state returns to BT_IDLE on release. The reset-pulse machine has two states: RS_IDLE goes to RS_PULSE on an accepted request edge, and RS_PULSE goes back to RS_IDLE when the pulse timer runs out.

Top module: `pwrbtn_rst_ctrl`

## Requirements
- R1: A press seen while `sys_off` is 1 makes `pwr_on_req` pulse once after exactly BOOT_MS ticks of `ms_tick`. A release before that produces no pulse.
- R2: A press that is held for HOLD_MS ticks makes `force_off` pulse high for exactly one cycle. This applies whatever the value of `sys_off` at the press.
- R3: Releasing the button cancels both the pending boot hold and the pending shutdown hold. No pulse follows, however many ticks pass afterwards.
- R4: From the cycle after a `force_off` pulse, `sys_rst_n` and `pmic_en_n` are both 0. `pmic_en_n` returns to 1 after PMIC_HOLD_MS further ticks.
- R5: When a boot hold completes during a PMIC hold window, the window ends at once. `pmic_en_n` goes to 1 in the same cycle that `pwr_on_req` pulses.
- R6: An `enter_s3` pulse while the button is held in the shutdown-hold phase makes `force_off` pulse in the next cycle. An `enter_s3` pulse with the button released does nothing.
- R7: A rising edge of `lid_open` while `sys_off` is 1 makes `pwr_on_req` pulse. A rising edge while `sys_off` is 0 does not.
- R8: A rising edge of `warm_req` drives `sys_rst_n` to 0 from the next cycle for RST_PULSE_MS ticks, after which it returns to 1.
- R9: A `warm_req` edge during a reset pulse is ignored, so the pulse ends on its original schedule. A level that stays high after the pulse starts nothing new.
- R10: The reset hold set by a forced shutdown stays in force after the PMIC window ends. It is released only by the next `pwr_on_req`.
- R11: After reset, `sys_rst_n` and `pmic_en_n` are 1 and `pwr_on_req` and `force_off` are 0.
- R12: After a forced shutdown, holding the button longer produces no further pulse until it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| btn_pressed | input | 1 | Debounced button level, 1 = pressed |
| lid_open | input | 1 | Lid level, 1 = open |
| warm_req | input | 1 | Warm-reset request from the processor, active high |
| sys_off | input | 1 | Sequencer reports the system is off |
| enter_s3 | input | 1 | Sequencer pulse on entry to S3 |
| pwr_on_req | output | 1 | One-cycle power-on request |
| force_off | output | 1 | One-cycle forced-shutdown pulse |
| sys_rst_n | output | 1 | Active-low system reset contribution |
| pmic_en_n | output | 1 | Active-low PMIC enable contribution |

## Verification
The bench sweeps the release point across each hold window, one tick either side of its limit. A timer that is off by one tick, or that keeps counting after release, shows up as a pulse count that is wrong by one. It also completes a boot hold inside a PMIC window, and a design that left the window running would keep `pmic_en_n` low after the power-on request. It checks that the reset hold outlives the PMIC window, and a design that tied the hold to that window would release `sys_rst_n` too early. Finally, it re-raises the warm request in the middle of a pulse, and a design that re-armed on that edge would stretch the pulse past its schedule.

// File: rtl/pbrc_pkg.sv
package pbrc_pkg;

    typedef enum logic [1:0] {
        BT_IDLE,
        BT_BOOT_WAIT,
        BT_HOLD,
        BT_SPENT
    } btn_state_e;

    typedef enum logic {
        RS_IDLE,
        RS_PULSE
    } rst_state_e;

    // timer slots in the shared timer bank
    localparam int TMR_BOOT  = 0;
    localparam int TMR_HOLD  = 1;
    localparam int TMR_PMIC  = 2;
    localparam int TMR_RST   = 3;
    localparam int TMR_COUNT = 4;

endpackage

// File: rtl/pbrc_timer.sv
// Cancellable down-counter paced by a millisecond tick.
// Priority: arm over cancel over counting.
module pbrc_timer #(
    parameter int unsigned CW    = 8,
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic cancel,
    output logic busy,
    output logic expire
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy   <= 1'b0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (arm) begin
                cnt_q <= CW'(LIMIT);
                busy  <= 1'b1;
            end else if (cancel) begin
                busy <= 1'b0;
            end else if (busy && tick) begin
                if (cnt_q == CW'(1)) begin
                    busy   <= 1'b0;
                    expire <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pbrc_btn_fsm.sv
// Button hold state machine: boot hold, shutdown hold, release cancel.
module pbrc_btn_fsm
    import pbrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic btn_pressed,
    input  logic sys_off,
    input  logic enter_s3,
    input  logic boot_exp,
    input  logic hold_exp,
    output logic boot_arm,
    output logic hold_arm,
    output logic btn_cancel,
    output logic boot_go,
    output logic force_go,
    output logic holding
);

    btn_state_e st_q, st_d;
    logic       btn_q;
    logic       press, release_ev;
    logic       boot_go_d, force_go_d;

    assign press      = btn_pressed & ~btn_q;
    assign release_ev = ~btn_pressed & btn_q;
    assign holding    = (st_q == BT_HOLD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BT_IDLE;
            btn_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            btn_q <= btn_pressed;
        end
    end

    // next state and timer controls
    always_comb begin
        st_d       = st_q;
        boot_arm   = 1'b0;
        hold_arm   = 1'b0;
        btn_cancel = 1'b0;
        boot_go_d  = 1'b0;
        force_go_d = 1'b0;
        unique case (st_q)
            BT_IDLE: begin
                if (press) begin
                    hold_arm = 1'b1;
                    if (sys_off) begin
                        boot_arm = 1'b1;
                        st_d     = BT_BOOT_WAIT;
                    end else begin
                        st_d = BT_HOLD;
                    end
                end
            end
            BT_BOOT_WAIT: begin
                if (release_ev) begin
                    btn_cancel = 1'b1;
                    st_d       = BT_IDLE;
                end else if (hold_exp) begin
                    btn_cancel = 1'b1;
                    force_go_d = 1'b1;
                    st_d       = BT_SPENT;
                end else if (boot_exp) begin
                    boot_go_d = 1'b1;
                    st_d      = BT_HOLD;
                end
            end
            BT_HOLD: begin
                if (release_ev) begin
                    btn_cancel = 1'b1;
                    st_d       = BT_IDLE;
                end else if (hold_exp || enter_s3) begin
                    btn_cancel = 1'b1;
                    force_go_d = 1'b1;
                    st_d       = BT_SPENT;
                end
            end
            BT_SPENT: begin
                if (release_ev) begin
                    st_d = BT_IDLE;
                end
            end
            default: st_d = BT_IDLE;
        endcase
    end

    // registered pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_go  <= 1'b0;
            force_go <= 1'b0;
        end else begin
            boot_go  <= boot_go_d;
            force_go <= force_go_d;
        end
    end

endmodule

// File: rtl/pbrc_rst_fsm.sv
// Warm-reset pulse state machine: edge accepted only while idle.
module pbrc_rst_fsm
    import pbrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic warm_req,
    input  logic tmr_busy,
    input  logic tmr_exp,
    output logic tmr_arm,
    output logic pulse_on
);

    rst_state_e st_q, st_d;
    logic       warm_q;
    logic       warm_edge;

    assign warm_edge = warm_req & ~warm_q;
    assign pulse_on  = (st_q == RS_PULSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RS_IDLE;
            warm_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            warm_q <= warm_req;
        end
    end

    always_comb begin
        st_d    = st_q;
        tmr_arm = 1'b0;
        unique case (st_q)
            RS_IDLE: begin
                if (warm_edge && !tmr_busy) begin
                    tmr_arm = 1'b1;
                    st_d    = RS_PULSE;
                end
            end
            RS_PULSE: begin
                if (tmr_exp) begin
                    st_d = RS_IDLE;
                end
            end
            default: st_d = RS_IDLE;
        endcase
    end

endmodule

// File: rtl/pwrbtn_rst_ctrl.sv
module pwrbtn_rst_ctrl
    import pbrc_pkg::*;
#(
    parameter int unsigned BOOT_MS      = 10,
    parameter int unsigned HOLD_MS      = 8000,
    parameter int unsigned PMIC_HOLD_MS = 9000,
    parameter int unsigned RST_PULSE_MS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic btn_pressed,
    input  logic lid_open,
    input  logic warm_req,
    input  logic sys_off,
    input  logic enter_s3,
    output logic pwr_on_req,
    output logic force_off,
    output logic sys_rst_n,
    output logic pmic_en_n
);

    localparam int unsigned LIM [TMR_COUNT] = '{BOOT_MS, HOLD_MS, PMIC_HOLD_MS, RST_PULSE_MS};
    localparam int unsigned MAX_AB = (BOOT_MS > HOLD_MS) ? BOOT_MS : HOLD_MS;
    localparam int unsigned MAX_CD = (PMIC_HOLD_MS > RST_PULSE_MS) ? PMIC_HOLD_MS : RST_PULSE_MS;
    localparam int unsigned MAX_LIM = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned CW = $clog2(MAX_LIM + 1);

    logic [TMR_COUNT-1:0] t_arm, t_cancel, t_busy, t_exp;

    logic boot_arm, hold_arm, btn_cancel, boot_go, force_go, btn_holding;
    logic rst_arm, rst_pulse_on;
    logic lid_q, on_src, force_hold_q;

    generate
        for (genvar g = 0; g < TMR_COUNT; g++) begin : g_tmr
            pbrc_timer #(
                .CW   (CW),
                .LIMIT(LIM[g])
            ) tmr_i (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (ms_tick),
                .arm   (t_arm[g]),
                .cancel(t_cancel[g]),
                .busy  (t_busy[g]),
                .expire(t_exp[g])
            );
        end
    endgenerate

    pbrc_btn_fsm btn_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .btn_pressed(btn_pressed),
        .sys_off    (sys_off),
        .enter_s3   (enter_s3),
        .boot_exp   (t_exp[TMR_BOOT]),
        .hold_exp   (t_exp[TMR_HOLD]),
        .boot_arm   (boot_arm),
        .hold_arm   (hold_arm),
        .btn_cancel (btn_cancel),
        .boot_go    (boot_go),
        .force_go   (force_go),
        .holding    (btn_holding)
    );

    pbrc_rst_fsm rstp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .warm_req(warm_req),
        .tmr_busy(t_busy[TMR_RST]),
        .tmr_exp (t_exp[TMR_RST]),
        .tmr_arm (rst_arm),
        .pulse_on(rst_pulse_on)
    );

    // timer bank wiring
    assign t_arm[TMR_BOOT]    = boot_arm;
    assign t_cancel[TMR_BOOT] = btn_cancel;
    assign t_arm[TMR_HOLD]    = hold_arm;
    assign t_cancel[TMR_HOLD] = btn_cancel;
    assign t_arm[TMR_PMIC]    = force_go;
    assign t_cancel[TMR_PMIC] = boot_go;
    assign t_arm[TMR_RST]     = rst_arm;
    assign t_cancel[TMR_RST]  = 1'b0;

    // power-on sources: completed boot hold or lid opening while off
    assign on_src = boot_go | (lid_open & ~lid_q & sys_off);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lid_q        <= 1'b0;
            pwr_on_req   <= 1'b0;
            force_hold_q <= 1'b0;
        end else begin
            lid_q      <= lid_open;
            pwr_on_req <= on_src;
            if (force_go) begin
                force_hold_q <= 1'b1;
            end else if (on_src) begin
                force_hold_q <= 1'b0;
            end
        end
    end

    // output stage
    always_comb begin
        force_off = force_go;
        sys_rst_n = ~(force_hold_q | rst_pulse_on);
        pmic_en_n = ~t_busy[TMR_PMIC];
    end

endmodule

// File: rtl/pbrc_chk.sv
module pbrc_chk (
    input logic clk,
    input logic rst_n,
    input logic btn_pressed,
    input logic enter_s3,
    input logic warm_req,
    input logic force_off,
    input logic sys_rst_n,
    input logic pmic_en_n,
    input logic holding,
    input logic pulse_on,
    input logic boot_busy,
    input logic hold_busy
);

    // R2
    force_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> !force_off);

    // R3
    release_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(btn_pressed) |=> (!boot_busy && !hold_busy));

    // R4
    force_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!sys_rst_n && !pmic_en_n));

    // R6
    s3_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_s3 && btn_pressed && holding) |=> force_off);

    // R8
    warm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(warm_req) && !pulse_on) |=> !sys_rst_n);

endmodule

bind pwrbtn_rst_ctrl pbrc_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .btn_pressed(btn_pressed),
    .enter_s3   (enter_s3),
    .warm_req   (warm_req),
    .force_off  (force_off),
    .sys_rst_n  (sys_rst_n),
    .pmic_en_n  (pmic_en_n),
    .holding    (btn_holding),
    .pulse_on   (rst_pulse_on),
    .boot_busy  (t_busy[0]),
    .hold_busy  (t_busy[1])
);

// File: tb/pwrbtn_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwrbtn_rst_ctrl_tb_top;

    localparam int BOOT = 3;
    localparam int HOLD = 8;
    localparam int PMIC = 12;
    localparam int RSTP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, btn = 1'b0, lid = 1'b0, warm = 1'b0, soff = 1'b0, s3 = 1'b0;
    logic pwr_on_req, force_off, sys_rst_n, pmic_en_n;

    int n_chk = 0, n_bad = 0;
    int n_on = 0, n_off = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwrbtn_rst_ctrl #(
        .BOOT_MS(BOOT), .HOLD_MS(HOLD), .PMIC_HOLD_MS(PMIC), .RST_PULSE_MS(RSTP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn_pressed(btn),
        .lid_open(lid), .warm_req(warm), .sys_off(soff), .enter_s3(s3),
        .pwr_on_req(pwr_on_req), .force_off(force_off),
        .sys_rst_n(sys_rst_n), .pmic_en_n(pmic_en_n)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (pwr_on_req) n_on++;
            if (force_off) n_off++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
            waitn(3);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            finish_run();
        end
    end

    initial begin
        int b_on, b_off;
        waitn(5);
        rst_n = 1'b1;
        waitn(2);
        // R11 reset state
        chk(sys_rst_n == 1'b1, "R11", sys_rst_n, 1);
        chk(pmic_en_n == 1'b1, "R11", pmic_en_n, 1);
        chk(n_on == 0, "R11", n_on, 0);
        chk(n_off == 0, "R11", n_off, 0);

        // R1 / R3 boot hold sweep, system off
        soff = 1'b1;
        for (int k = 0; k <= BOOT + 1; k++) begin
            b_on = n_on; b_off = n_off;
            @(negedge clk) btn = 1'b1;
            do_ticks(k);
            chk(n_on - b_on == ((k >= BOOT) ? 1 : 0), "R1", n_on - b_on, (k >= BOOT) ? 1 : 0);
            @(negedge clk) btn = 1'b0;
            do_ticks(HOLD + 1);
            chk(n_on - b_on == ((k >= BOOT) ? 1 : 0), "R3", n_on - b_on, (k >= BOOT) ? 1 : 0);
            chk(n_off == b_off, "R3", n_off - b_off, 0);
        end

        // R2 / R12 shutdown hold sweep, system on
        soff = 1'b0;
        for (int k = HOLD - 2; k <= HOLD + 1; k++) begin
            b_off = n_off;
            @(negedge clk) btn = 1'b1;
            do_ticks(k);
            chk(n_off - b_off == ((k >= HOLD) ? 1 : 0), "R2", n_off - b_off, (k >= HOLD) ? 1 : 0);
            if (k >= HOLD) begin
                do_ticks(HOLD);
                chk(n_off - b_off == 1, "R12", n_off - b_off, 1);
            end
            @(negedge clk) btn = 1'b0;
            do_ticks(PMIC + 1);
            chk(pmic_en_n == 1'b1, "R4", pmic_en_n, 1);
        end

        // R10 hold persists after PMIC window; R7 lid while on is ignored
        b_on = n_on;
        chk(sys_rst_n == 1'b0, "R10", sys_rst_n, 0);
        @(negedge clk) lid = 1'b1;
        waitn(3);
        chk(n_on == b_on, "R7", n_on - b_on, 0);
        chk(sys_rst_n == 1'b0, "R10", sys_rst_n, 0);
        @(negedge clk) lid = 1'b0;
        soff = 1'b1;
        waitn(2);
        @(negedge clk) lid = 1'b1;
        waitn(3);
        chk(n_on - b_on == 1, "R7", n_on - b_on, 1);
        chk(sys_rst_n == 1'b1, "R10", sys_rst_n, 1);
        @(negedge clk) lid = 1'b0;

        // R4 PMIC window length
        soff = 1'b0;
        b_off = n_off;
        @(negedge clk) btn = 1'b1;
        do_ticks(HOLD);
        chk(n_off - b_off == 1, "R4", n_off - b_off, 1);
        chk(sys_rst_n == 1'b0, "R4", sys_rst_n, 0);
        chk(pmic_en_n == 1'b0, "R4", pmic_en_n, 0);
        @(negedge clk) btn = 1'b0;
        do_ticks(PMIC - 1);
        chk(pmic_en_n == 1'b0, "R4", pmic_en_n, 0);
        do_ticks(1);
        chk(pmic_en_n == 1'b1, "R4", pmic_en_n, 1);

        // R5 boot hold cuts the PMIC window short
        b_off = n_off;
        @(negedge clk) btn = 1'b1;
        do_ticks(HOLD);
        chk(n_off - b_off == 1, "R5", n_off - b_off, 1);
        @(negedge clk) btn = 1'b0;
        soff = 1'b1;
        b_on = n_on;
        @(negedge clk) btn = 1'b1;
        do_ticks(BOOT - 1);
        chk(pmic_en_n == 1'b0, "R5", pmic_en_n, 0);
        do_ticks(1);
        chk(pmic_en_n == 1'b1, "R5", pmic_en_n, 1);
        chk(n_on - b_on == 1, "R5", n_on - b_on, 1);
        chk(sys_rst_n == 1'b1, "R10", sys_rst_n, 1);
        @(negedge clk) btn = 1'b0;
        do_ticks(2);

        // R6 entry to S3 with and without the button held
        soff = 1'b0;
        b_off = n_off;
        @(negedge clk) s3 = 1'b1;
        @(negedge clk) s3 = 1'b0;
        waitn(2);
        chk(n_off == b_off, "R6", n_off - b_off, 0);
        @(negedge clk) btn = 1'b1;
        do_ticks(2);
        @(negedge clk) s3 = 1'b1;
        @(negedge clk) s3 = 1'b0;
        waitn(2);
        chk(n_off - b_off == 1, "R6", n_off - b_off, 1);
        do_ticks(HOLD);
        chk(n_off - b_off == 1, "R12", n_off - b_off, 1);
        @(negedge clk) btn = 1'b0;
        do_ticks(PMIC);
        soff = 1'b1;
        @(negedge clk) lid = 1'b1;
        waitn(3);
        @(negedge clk) lid = 1'b0;
        chk(sys_rst_n == 1'b1, "R10", sys_rst_n, 1);

        // R8 warm reset pulse length
        @(negedge clk) warm = 1'b1;
        waitn(1);
        chk(sys_rst_n == 1'b0, "R8", sys_rst_n, 0);
        do_ticks(RSTP - 1);
        chk(sys_rst_n == 1'b0, "R8", sys_rst_n, 0);
        do_ticks(1);
        chk(sys_rst_n == 1'b1, "R8", sys_rst_n, 1);
        @(negedge clk) warm = 1'b0;
        waitn(2);

        // R9 re-request mid pulse is ignored; a held level starts nothing
        @(negedge clk) warm = 1'b1;
        do_ticks(2);
        @(negedge clk) warm = 1'b0;
        @(negedge clk) warm = 1'b1;
        waitn(1);
        do_ticks(RSTP - 2);
        chk(sys_rst_n == 1'b1, "R9", sys_rst_n, 1);
        do_ticks(RSTP);
        chk(sys_rst_n == 1'b1, "R9", sys_rst_n, 1);
        @(negedge clk) warm = 1'b0;
        waitn(2);

        done = 1'b1;
        finish_run();
    end

endmodule